// File: doc/BRIEF.md
# Configurable Serial Peripheral Interface Controller

This block is a four-wire serial peripheral interface engine that can act as the clock-owning master or as a slave. Software sets it up through a small synchronous register port. The settings are the operating mode, the idle level of the serial clock, whether data is launched half a clock ahead of the first edge, whether the data output is driven at all, and the word length from 1 to 16 bits. In master mode, a separate register holds a baud divider that sets the serial clock period in peripheral clock cycles, with 125 distinct settings.

A write to the data register loads the transmit shifter. In master mode the same write also starts a transfer. The word is taken left-justified and goes out most significant bit first. Incoming bits enter from the right, so the received word sits in the low bits of the data register and the upper bits keep what was shifted out. Completion raises a receive flag and a transmit flag, and each flag drives an interrupt line that software can also poll. A word that finishes before the previous one was read raises a sticky overrun flag.

In slave mode the serial clock, the data input and the select are first passed through a synchronizer. While the select is inactive, the shifter keeps its state and the slave data output is released.

Top module: `sercom_spi_core`

## Requirements
- R1: CTRL bit0 selects master (1) or slave (0). In master mode `sclk_oe` is 1, `miso_oe` is 0, and `ste_n_o` is 0 while a transfer runs and 1 otherwise. In slave mode `sclk_oe` is 0 and `ste_n_o` is 1.
- R2: CTRL bits 7:4 hold the word length minus one (1 to 16 bits). The word written to DATA (address 3) is sent from bit 15 downward. A DATA read returns the shift register after the word: received bits in the low positions, the written word's remaining bits shifted up above them.
- R3: BAUD (address 1) bits 6:0 hold a divider d. A master transfer of L bits takes L*P peripheral clock cycles from the DATA write until the completion flags show, where P = d+1 for d of 3 or more and P = 4 for d of 0 to 2.
- R4: CTRL bit1 is the idle level of the serial clock. With CTRL bit2 (phase) clear, a bit changes on the edge leaving idle and is sampled on the edge back to idle. With bit2 set, the first bit is on the data line before the first edge, bits are sampled on the edge leaving idle, and they change on the edge back to idle.
- R5: When CTRL bit3 (transmit enable) is 0, `mosi_oe` and `miso_oe` stay 0 and words are still received.
- R6: STATUS (address 2) bit2 and `irq_rx` rise when a word completes. A DATA read clears bit2.
- R7: STATUS bit1 and `irq_tx` rise when a word completes. A DATA write clears bit1.
- R8: STATUS bit3 (overrun) rises when a word completes while bit2 is still set. It stays set until STATUS is written with bit3 at 1. `irq_rx` is the OR of bits 2 and 3.
- R9: In slave mode, while `ste_n_i` is high, `miso_oe` is 0 and serial clock edges are ignored. A partly shifted word resumes when the select returns.
- R10: STATUS bit0 shows a master transfer in progress. A DATA write during that time is ignored.
- R11: After reset all registers and flags are 0, `sclk_o` is 0 and `ste_n_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (read side effects) |
| addr | input | 2 | Register select: 0 CTRL, 1 BAUD, 2 STATUS, 3 DATA |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for the selected register (combinational) |
| irq_rx | output | 1 | Receive or overrun flag |
| irq_tx | output | 1 | Transmit completion flag |
| sclk_i | input | 1 | Serial clock from a master (slave mode) |
| sclk_o | output | 1 | Serial clock driven in master mode |
| sclk_oe | output | 1 | Drive enable for `sclk_o` |
| mosi_i | input | 1 | Master-to-slave data in (slave mode) |
| mosi_o | output | 1 | Master-to-slave data out |
| mosi_oe | output | 1 | Drive enable for `mosi_o` |
| miso_i | input | 1 | Slave-to-master data in (master mode) |
| miso_o | output | 1 | Slave-to-master data out |
| miso_oe | output | 1 | Drive enable for `miso_o` |
| ste_n_i | input | 1 | Active-low slave select input |
| ste_n_o | output | 1 | Active-low select driven as master |

## Verification
In master mode the DATA write is taken at one edge. The serial clock first leaves idle one cycle later, and both flags rise exactly L*P cycles after the write edge. The bench counts cycles from the write up to the first cycle in which `irq_tx` is seen, and expects that exact number. Phase checks look at `sclk_o` and `mosi_o` half a cycle after the write edge and again after the next edge. In slave mode the inputs pass through a two-stage synchronizer plus an edge register, so outputs follow a bench edge by about three cycles. The bench holds each serial clock level for eight cycles and samples just before it changes the level.

// File: rtl/sercom_spi_pkg.sv
package sercom_spi_pkg;

    localparam int WORD_W     = 16;
    localparam int LEN_W      = $clog2(WORD_W);
    localparam int DIV_W      = 7;
    localparam int PER_W      = DIV_W + 1;
    localparam int MIN_PERIOD = 4;

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_BAUD = 2'd1,
        REG_STAT = 2'd2,
        REG_DATA = 2'd3
    } reg_sel_e;

    // control register, bit0 at the right
    typedef struct packed {
        logic [LEN_W-1:0] len_m1;
        logic             tx_en;
        logic             cpha;
        logic             cpol;
        logic             master;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    typedef struct packed {
        logic ovr;
        logic rx_full;
        logic tx_done;
        logic busy;
    } stat_t;

    localparam int STAT_W = $bits(stat_t);

    // serial clock period in peripheral clocks for a divider setting
    function automatic logic [PER_W-1:0] period_of(input logic [DIV_W-1:0] div);
        logic [PER_W-1:0] p;
        p = {1'b0, div} + 1'b1;
        return (p < PER_W'(MIN_PERIOD)) ? PER_W'(MIN_PERIOD) : p;
    endfunction

endpackage

// File: rtl/sercom_spi_baud.sv
module sercom_spi_baud
    import sercom_spi_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [DIV_W-1:0] div,
    input  logic [LEN_W-1:0] len_m1,
    output logic             busy,
    output logic             act,
    output logic             lead,
    output logic             trail,
    output logic             fin
);

    logic [PER_W-1:0] per;
    logic [PER_W-1:0] half;
    logic [PER_W-1:0] cnt;
    logic [LEN_W-1:0] bits;
    logic             wrap;

    always_comb begin
        per   = period_of(div);
        half  = per >> 1;
        wrap  = (cnt == per - 1'b1);
        lead  = busy && (cnt == '0);
        trail = busy && (cnt == half);
        fin   = busy && wrap && (bits == len_m1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            act  <= 1'b0;
            cnt  <= '0;
            bits <= '0;
        end else if (!busy) begin
            if (start) begin
                busy <= 1'b1;
                cnt  <= '0;
                bits <= '0;
            end
        end else begin
            if (lead)  act <= 1'b1;
            if (trail) act <= 1'b0;
            if (wrap) begin
                cnt  <= '0;
                bits <= bits + 1'b1;
                if (bits == len_m1) busy <= 1'b0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R3: the in-period counter never reaches the period
    a_r3_count_in_period: assert property (@(posedge clk) disable iff (rst)
        busy |-> (cnt < per));

    // R3: a transfer ends only on its final count
    a_r3_end_on_final: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(fin));

    // R1: the clock rests at idle outside a transfer
    a_r1_idle_outside: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !act);

endmodule

// File: rtl/sercom_spi_sfront.sv
module sercom_spi_sfront
    import sercom_spi_pkg::*;
#(
    parameter int STAGES = 2
)(
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic cpol,
    input  logic sclk_i,
    input  logic mosi_i,
    input  logic ste_n_i,
    output logic lead,
    output logic trail,
    output logic data,
    output logic sel
);

    logic [STAGES-1:0] c_q;
    logic [STAGES-1:0] d_q;
    logic [STAGES-1:0] s_q;
    logic              c_last;
    logic              moved;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) begin
                    c_q <= '0;
                    d_q <= '0;
                    s_q <= '1;
                end else begin
                    c_q <= sclk_i;
                    d_q <= mosi_i;
                    s_q <= ste_n_i;
                end
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) begin
                    c_q <= '0;
                    d_q <= '0;
                    s_q <= '1;
                end else begin
                    c_q <= {c_q[STAGES-2:0], sclk_i};
                    d_q <= {d_q[STAGES-2:0], mosi_i};
                    s_q <= {s_q[STAGES-2:0], ste_n_i};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) c_last <= 1'b0;
        else     c_last <= c_q[STAGES-1];
    end

    always_comb begin
        sel   = !s_q[STAGES-1];
        data  = d_q[STAGES-1];
        moved = enable && sel && (c_q[STAGES-1] != c_last);
        lead  = moved && (c_q[STAGES-1] != cpol);
        trail = moved && (c_q[STAGES-1] == cpol);
    end

    // R9: no edge is passed on while deselected
    a_r9_quiet_deselected: assert property (@(posedge clk) disable iff (rst)
        (s_q[STAGES-1]) |-> !(lead || trail));

endmodule

// File: rtl/sercom_spi_shift.sv
module sercom_spi_shift
    import sercom_spi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WORD_W-1:0] load_val,
    input  logic              cpha,
    input  logic              lead,
    input  logic              trail,
    input  logic              din,
    input  logic [LEN_W-1:0]  len_m1,
    output logic [WORD_W-1:0] sr,
    output logic [WORD_W-1:0] sr_next,
    output logic              dout,
    output logic              last
);

    logic [LEN_W-1:0] bitcnt;
    logic             sample;
    logic             launch;

    always_comb begin
        sample  = cpha ? lead : trail;
        launch  = cpha ? trail : lead;
        sr_next = {sr[WORD_W-2:0], din};
        last    = sample && (bitcnt == len_m1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sr     <= '0;
            dout   <= 1'b0;
            bitcnt <= '0;
        end else if (load) begin
            sr     <= load_val;
            bitcnt <= '0;
            if (cpha) dout <= load_val[WORD_W-1];
        end else begin
            if (sample) begin
                sr     <= sr_next;
                bitcnt <= (bitcnt == len_m1) ? '0 : bitcnt + 1'b1;
            end
            if (launch) dout <= sr[WORD_W-1];
        end
    end

    // R4: one clock edge at a time reaches the shifter
    a_r4_one_edge: assert property (@(posedge clk) disable iff (rst)
        !(lead && trail));

    // R2: the bit counter stays within the programmed length
    a_r2_count_bound: assert property (@(posedge clk) disable iff (rst)
        bitcnt <= len_m1);

endmodule

// File: rtl/sercom_spi_core.sv
module sercom_spi_core
    import sercom_spi_pkg::*;
#(
    parameter int SYNC_STAGES = 2
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [1:0]        addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    output logic              irq_rx,
    output logic              irq_tx,
    input  logic              sclk_i,
    output logic              sclk_o,
    output logic              sclk_oe,
    input  logic              mosi_i,
    output logic              mosi_o,
    output logic              mosi_oe,
    input  logic              miso_i,
    output logic              miso_o,
    output logic              miso_oe,
    input  logic              ste_n_i,
    output logic              ste_n_o
);

    reg_sel_e          sel;
    ctrl_t             ctrl;
    stat_t             stat;
    stat_t             wstat;
    logic [DIV_W-1:0]  baud;
    logic [WORD_W-1:0] rxbuf;
    logic              rx_full, tx_done, ovr;

    logic wr_ctrl, wr_baud, wr_stat, wr_data, rd_data;
    logic m_busy, m_act, m_lead, m_trail, m_fin;
    logic s_lead, s_trail, s_data, s_sel;
    logic lead, trail, din, load, word_done, dout, s_last;
    logic [WORD_W-1:0] sr, sr_next, capture;

    always_comb begin
        sel     = reg_sel_e'(addr);
        wstat   = stat_t'(wdata[STAT_W-1:0]);
        wr_ctrl = wr_en && (sel == REG_CTRL);
        wr_baud = wr_en && (sel == REG_BAUD);
        wr_stat = wr_en && (sel == REG_STAT);
        wr_data = wr_en && (sel == REG_DATA);
        rd_data = rd_en && (sel == REG_DATA);
        load    = wr_data && !(ctrl.master && m_busy);
        lead    = ctrl.master ? m_lead  : s_lead;
        trail   = ctrl.master ? m_trail : s_trail;
        din     = ctrl.master ? miso_i  : s_data;
        word_done = ctrl.master ? m_fin : s_last;
        capture   = ctrl.master ? sr    : sr_next;
        stat    = '{ovr: ovr, rx_full: rx_full, tx_done: tx_done, busy: m_busy};
    end

    sercom_spi_baud u_baud (
        .clk    (clk),
        .rst    (rst),
        .start  (wr_data && ctrl.master),
        .div    (baud),
        .len_m1 (ctrl.len_m1),
        .busy   (m_busy),
        .act    (m_act),
        .lead   (m_lead),
        .trail  (m_trail),
        .fin    (m_fin)
    );

    sercom_spi_sfront #(.STAGES(SYNC_STAGES)) u_front (
        .clk     (clk),
        .rst     (rst),
        .enable  (!ctrl.master),
        .cpol    (ctrl.cpol),
        .sclk_i  (sclk_i),
        .mosi_i  (mosi_i),
        .ste_n_i (ste_n_i),
        .lead    (s_lead),
        .trail   (s_trail),
        .data    (s_data),
        .sel     (s_sel)
    );

    sercom_spi_shift u_shift (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_val (wdata),
        .cpha     (ctrl.cpha),
        .lead     (lead),
        .trail    (trail),
        .din      (din),
        .len_m1   (ctrl.len_m1),
        .sr       (sr),
        .sr_next  (sr_next),
        .dout     (dout),
        .last     (s_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl    <= '0;
            baud    <= '0;
            rxbuf   <= '0;
            rx_full <= 1'b0;
            tx_done <= 1'b0;
            ovr     <= 1'b0;
        end else begin
            if (wr_ctrl) ctrl <= ctrl_t'(wdata[CTRL_W-1:0]);
            if (wr_baud) baud <= wdata[DIV_W-1:0];
            if (word_done) begin
                rxbuf   <= capture;
                rx_full <= 1'b1;
                tx_done <= 1'b1;
                if (rx_full && !rd_data) ovr <= 1'b1;
            end else if (rd_data) begin
                rx_full <= 1'b0;
            end
            if (wr_data) tx_done <= 1'b0;
            if (wr_stat && wstat.ovr) ovr <= 1'b0;
        end
    end

    always_comb begin
        case (sel)
            REG_CTRL: rdata = WORD_W'(ctrl);
            REG_BAUD: rdata = WORD_W'(baud);
            REG_STAT: rdata = WORD_W'(stat);
            default:  rdata = rxbuf;
        endcase
        irq_rx  = rx_full || ovr;
        irq_tx  = tx_done;
        sclk_o  = m_act ^ ctrl.cpol;
        sclk_oe = ctrl.master;
        mosi_o  = dout;
        miso_o  = dout;
        mosi_oe = ctrl.master && ctrl.tx_en;
        miso_oe = !ctrl.master && ctrl.tx_en && s_sel;
        ste_n_o = !(ctrl.master && m_busy);
    end

    // R8: overrun leaves only through a clearing status write
    a_r8_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
        $fell(ovr) |-> $past(wr_stat && wdata[3]));

    // R6: the receive flag rises only with a completed word
    a_r6_rx_on_done: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_full) |-> $past(word_done));

    // R5: transmit disabled keeps both data outputs released
    a_r5_tx_off_released: assert property (@(posedge clk) disable iff (rst)
        !ctrl.tx_en |-> (!mosi_oe && !miso_oe));

    // R1: a slave never drives the clock or its select output
    a_r1_slave_pins: assert property (@(posedge clk) disable iff (rst)
        !ctrl.master |-> (!sclk_oe && ste_n_o));

    // R10: the master shifter is untouched by writes in flight
    a_r10_no_reload_busy: assert property (@(posedge clk) disable iff (rst)
        (ctrl.master && m_busy && wr_data) |=> (stat.busy || $past(m_fin)));

endmodule

// File: tb/sercom_spi_core_test.sv
`timescale 1ns/1ps
module sercom_spi_core_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [15:0] wdata = 16'h0;
    logic [15:0] rdata;
    logic        irq_rx, irq_tx;
    logic        sclk_i = 1'b0, mosi_i = 1'b0, ste_n_i = 1'b1;
    logic        sclk_o, sclk_oe, mosi_o, mosi_oe, miso_o, miso_oe, ste_n_o;
    logic        miso_w;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    // loopback with a pull-up when the master output is released
    assign miso_w = mosi_oe ? mosi_o : 1'b1;

    sercom_spi_core uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq_rx(irq_rx), .irq_tx(irq_tx),
        .sclk_i(sclk_i), .sclk_o(sclk_o), .sclk_oe(sclk_oe),
        .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
        .miso_i(miso_w), .miso_o(miso_o), .miso_oe(miso_oe),
        .ste_n_i(ste_n_i), .ste_n_o(ste_n_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_rd(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    function automatic logic [15:0] ctrl_word(input bit m, input bit pol, input bit pha,
                                              input bit txe, input int len);
        return 16'(((len - 1) << 4) | (int'(txe) << 3) | (int'(pha) << 2) | (int'(pol) << 1) | int'(m));
    endfunction

    function automatic logic [15:0] rotl(input logic [15:0] v, input int n);
        logic [31:0] w;
        w = {v, v} << n;
        return w[31:16];
    endfunction

    function automatic logic [15:0] shift_in(input logic [15:0] v, input int n, input logic [15:0] bits);
        logic [31:0] w;
        w = ({16'h0, v} << n) | {16'h0, bits};
        return w[15:0];
    endfunction

    // write DATA and count cycles until the transmit flag shows
    task automatic master_xfer(input logic [15:0] tx, output int n);
        reg_wr(2'd3, tx);
        n = 0;
        while (!irq_tx && n < 5000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic t_reset();
        logic [15:0] d;
        chk("R11 irq_rx after reset", irq_rx, 0);
        chk("R11 irq_tx after reset", irq_tx, 0);
        chk("R11 sclk_o after reset", sclk_o, 0);
        chk("R11 ste_n_o after reset", ste_n_o, 1);
        reg_rd(2'd0, d); chk("R11 CTRL after reset", d, 16'h0);
        reg_rd(2'd2, d); chk("R11 STATUS after reset", d, 16'h0);
        chk("R1 slave sclk_oe", sclk_oe, 0);
    endtask

    task automatic t_modes();
        logic [15:0] d;
        int n;
        for (int m = 0; m < 4; m++) begin
            bit pol = m[1];
            bit pha = m[0];
            logic [15:0] tx = 16'hA53C ^ 16'(m * 16'h1111);
            int len = 5 + 3 * m;
            reg_wr(2'd0, ctrl_word(1, pol, pha, 1, len));
            reg_wr(2'd1, 16'd5);
            chk("R4 idle clock level", sclk_o, 32'(pol));
            master_xfer(tx, n);
            reg_rd(2'd3, d);
            chk("R2 R4 loopback word", d, rotl(tx, len));
        end
        // boundary lengths
        reg_wr(2'd0, ctrl_word(1, 0, 0, 1, 1));
        master_xfer(16'h8001, n);
        reg_rd(2'd3, d); chk("R2 one-bit word", d, rotl(16'h8001, 1));
        reg_wr(2'd0, ctrl_word(1, 1, 1, 1, 16));
        master_xfer(16'h6E29, n);
        reg_rd(2'd3, d); chk("R2 sixteen-bit word", d, 16'h6E29);
    endtask

    task automatic t_phase(input bit pol, input bit pha);
        logic [15:0] tx = pha ? 16'h8000 : 16'h7FFF;
        logic [15:0] d;
        int n;
        reg_wr(2'd0, ctrl_word(1, pol, pha, 1, 4));
        reg_wr(2'd1, 16'd7);
        reg_wr(2'd3, tx);
        // half a cycle after the write edge
        chk("R4 clock still idle after write", sclk_o, 32'(pol));
        if (pha) chk("R4 first bit ahead of first edge", mosi_o, 32'(tx[15]));
        @(negedge clk);
        chk("R4 clock left idle", sclk_o, 32'(!pol));
        chk("R4 first bit at leading edge", mosi_o, 32'(tx[15]));
        chk("R1 master select low in transfer", ste_n_o, 0);
        chk("R1 master drives clock", sclk_oe, 1);
        reg_rd(2'd2, d);
        chk("R10 busy shown", d[0], 1);
        n = 0;
        while (!irq_tx && n < 5000) begin @(negedge clk); n++; end
        chk("R1 master select high after", ste_n_o, 1);
        reg_rd(2'd3, d);
    endtask

    task automatic t_baud();
        int divs[4] = '{0, 2, 3, 9};
        int pers[4] = '{4, 4, 4, 10};
        logic [15:0] d;
        int n;
        reg_wr(2'd0, ctrl_word(1, 0, 0, 1, 6));
        for (int i = 0; i < 4; i++) begin
            reg_wr(2'd1, 16'(divs[i]));
            master_xfer(16'h1234, n);
            chk("R3 transfer length in cycles", n, 6 * pers[i]);
            reg_rd(2'd3, d);
        end
        reg_wr(2'd1, 16'd127);
        reg_wr(2'd0, ctrl_word(1, 0, 0, 1, 2));
        master_xfer(16'hC000, n);
        chk("R3 largest divider", n, 2 * 128);
        reg_rd(2'd3, d);
    endtask

    task automatic t_flags();
        logic [15:0] d;
        int n;
        reg_wr(2'd0, ctrl_word(1, 0, 1, 1, 4));
        reg_wr(2'd1, 16'd3);
        master_xfer(16'hB000, n);
        chk("R6 irq_rx after word", irq_rx, 1);
        reg_rd(2'd2, d); chk("R6 R7 status after word", d, 16'h6);
        master_xfer(16'h5000, n);
        reg_rd(2'd2, d); chk("R8 overrun set", d, 16'hE);
        reg_rd(2'd3, d); chk("R8 newest word kept", d, rotl(16'h5000, 4));
        reg_rd(2'd2, d); chk("R6 read clears rx flag", d, 16'hA);
        chk("R8 irq_rx held by overrun", irq_rx, 1);
        reg_wr(2'd2, 16'h0);
        reg_rd(2'd2, d); chk("R8 overrun survives write without bit3", d, 16'hA);
        reg_wr(2'd2, 16'h8);
        reg_rd(2'd2, d); chk("R8 overrun cleared", d, 16'h2);
        chk("R8 irq_rx low", irq_rx, 0);
        reg_wr(2'd3, 16'hF000);
        chk("R7 data write clears tx flag", irq_tx, 0);
        n = 0;
        while (!irq_tx && n < 5000) begin @(negedge clk); n++; end
        reg_rd(2'd3, d);
    endtask

    task automatic t_busy_write();
        logic [15:0] d;
        int n;
        reg_wr(2'd0, ctrl_word(1, 0, 0, 1, 8));
        reg_wr(2'd1, 16'd3);
        reg_wr(2'd3, 16'h3C00);
        repeat (5) @(negedge clk);
        reg_wr(2'd3, 16'hFFFF);
        n = 0;
        while (!irq_tx && n < 5000) begin @(negedge clk); n++; end
        reg_rd(2'd3, d);
        chk("R10 write during transfer ignored", d, rotl(16'h3C00, 8));
    endtask

    task automatic t_tx_off();
        logic [15:0] d;
        int n;
        reg_wr(2'd0, ctrl_word(1, 0, 0, 0, 6));
        reg_wr(2'd3, 16'h0000);
        @(negedge clk);
        chk("R5 master output released", mosi_oe, 0);
        n = 0;
        while (!irq_tx && n < 5000) begin @(negedge clk); n++; end
        reg_rd(2'd3, d);
        chk("R5 reception continues", d, shift_in(16'h0000, 6, 16'h003F));
    endtask

    // one serial bit as external master, idle-low clock, phase clear
    task automatic s_bit(input logic b, output logic got);
        sclk_i = 1'b1; mosi_i = b;
        repeat (8) @(negedge clk);
        got = miso_o;
        sclk_i = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    task automatic t_slave();
        logic [15:0] tx = 16'hC3A5;
        logic [7:0]  pat = 8'h6D;
        logic [7:0]  seen = 8'h0;
        logic [15:0] d;
        logic        g;
        reg_wr(2'd0, ctrl_word(0, 0, 0, 1, 8));
        reg_wr(2'd3, tx);
        chk("R1 slave clock undriven", sclk_oe, 0);
        ste_n_i = 1'b0;
        repeat (8) @(negedge clk);
        chk("R9 slave drives when selected", miso_oe, 1);
        for (int k = 0; k < 4; k++) begin s_bit(pat[7-k], g); seen[7-k] = g; end
        ste_n_i = 1'b1;
        repeat (6) @(negedge clk);
        chk("R9 released when deselected", miso_oe, 0);
        for (int k = 0; k < 2; k++) begin
            sclk_i = 1'b1; mosi_i = 1'b1; repeat (8) @(negedge clk);
            sclk_i = 1'b0; repeat (8) @(negedge clk);
        end
        chk("R9 no completion while held", irq_rx, 0);
        ste_n_i = 1'b0;
        repeat (8) @(negedge clk);
        for (int k = 4; k < 8; k++) begin s_bit(pat[7-k], g); seen[7-k] = g; end
        repeat (4) @(negedge clk);
        chk("R2 slave sends from bit 15", seen, tx[15:8]);
        chk("R6 slave word flagged", irq_rx, 1);
        reg_rd(2'd3, d);
        chk("R9 R2 slave word resumed intact", d, {tx[7:0], pat});
        // transmit disabled in slave mode
        reg_wr(2'd0, ctrl_word(0, 0, 0, 0, 4));
        reg_wr(2'd3, 16'h0F0F);
        repeat (4) @(negedge clk);
        chk("R5 slave output released", miso_oe, 0);
        for (int k = 0; k < 4; k++) s_bit(k[0], g);
        repeat (4) @(negedge clk);
        reg_rd(2'd3, d);
        chk("R5 slave still receives", d, shift_in(16'h0F0F, 4, 16'h0005));
        ste_n_i = 1'b1;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_modes();
        t_phase(0, 0);
        t_phase(1, 1);
        t_phase(0, 1);
        t_baud();
        t_flags();
        t_busy_write();
        t_tx_off();
        t_slave();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog all requirements actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule